// File: doc/BRIEF.md
# Multi-Level Page Table Walker

This block turns a virtual address into a physical page base by reading translation entries from memory, one table level at a time, starting at the top level. A request carries the virtual address, the root table base, a translation mode, and three access flags: supervisor, store and instruction fetch. The mode sets the depth of the walk, the width of each table index and the size of each entry. Every table read goes out on a simple memory port, with one read in flight at a time.

When the walk reaches a leaf entry that grants the access, the walker writes the entry back with its accessed bit set. On a store it also sets the dirty bit. It then reports the page base. A leaf found above the lowest level is a large page, and the walker reduces it to the base of the 4 KiB page that holds the address. Any failure ends the walk with a fault flag and no base. Page caching and trap delivery belong to the caller.

Top module: `ptw_walker`

## Requirements
- R1: `req_mode` selects the geometry. 0 gives 2 levels, 10-bit indices and 4-byte entries. 1 gives 3 levels, 9-bit indices and 8-byte entries. 2 gives 4 levels, 9-bit indices and 8-byte entries. Value 3 is reserved and faults at once, with no memory access.
- R2: The address is valid only when bits 63 down to (va_bits-1) are all equal, where va_bits = 12 + levels × index width. Any other address faults with no memory access.
- R3: The walk starts at the top level, where shift = (levels-1) × index width, and lowers the shift by the index width at each level. The entry address is base + ((vaddr >> (12+shift)) masked to the index width) × entry size.
- R4: An entry address that is not below `MEM_BYTES` ends the walk with a fault, and that read is never issued.
- R5: Entry format: bit0 valid, bit1 table, bit2 user-allowed, bit3 supervisor-allowed, bit4 writable, bit5 executable, bit6 accessed, bit7 dirty, PPN = entry >> 10. An entry with valid=1 and table=1 makes the next base PPN << 12.
- R6: Any other entry must pass the permission rule: valid, table=0, the supervisor bit for a supervisor access (the user bit for a user access), writable for a store, and executable for a fetch. An entry that fails the rule faults with no write.
- R7: A leaf that passes is written back to its own address at its own size, with bit6 set and, for a store, bit7 set. The write happens before the walk completes.
- R8: The result base is (PPN | (vaddr>>12 masked to the low shift bits)) << 12.
- R9: A result base that is not below `MEM_BYTES` faults. The write-back still happens.
- R10: A table entry found at the lowest level faults.
- R11: `req_ready` is high only when idle. `done` is a one-cycle pulse, and `page_base` is 0 whenever `fault` is set. A read request holds its address and kind stable until it is accepted.
- R12: With 4-byte entries, bits 63:32 of the read data are ignored, and the entry is zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Walk request present |
| req_ready | output | 1 | Walker idle, request accepted |
| req_vaddr | input | 64 | Virtual address |
| req_root | input | 64 | Root table base address |
| req_mode | input | 2 | Translation geometry |
| req_supervisor | input | 1 | Supervisor access |
| req_store | input | 1 | Store access |
| req_fetch | input | 1 | Instruction fetch access |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_write | output | 1 | 1 = entry write-back, 0 = entry read |
| mem_req_wide | output | 1 | 1 = 8-byte access, 0 = 4-byte access |
| mem_req_addr | output | 64 | Byte address of the entry |
| mem_req_wdata | output | 64 | Write-back data |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Read data |
| done | output | 1 | Walk complete (one cycle) |
| fault | output | 1 | Walk failed (valid with done) |
| page_base | output | 64 | Physical page base (valid with done) |

## Verification
The assertions rely on three things from the memory side: it answers each accepted read exactly once with `mem_rsp_valid`, it never raises `mem_rsp_valid` when no read is outstanding, and it completes a write at the moment the write is accepted. The bench memory model follows these rules. It queues at most one response, presents that response for a single cycle after the accepting edge, and can hold `mem_req_ready` low on alternate cycles to exercise stalls. Requests are driven only while `req_ready` is high, and the entries are placed in memory before each walk begins.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    localparam int XLEN      = 64;
    localparam int PG_SHIFT  = 12;
    localparam int PPN_SHIFT = 10;
    localparam int LVL_W     = 2;
    localparam int SHIFT_W   = 6;

    typedef enum logic [1:0] {
        GEO_L2_N4 = 2'd0,
        GEO_L3_N8 = 2'd1,
        GEO_L4_N8 = 2'd2,
        GEO_RSVD  = 2'd3
    } geo_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_REQ,
        ST_RD_WAIT,
        ST_WB,
        ST_DONE
    } walk_st_e;

    // Entry bit positions (own layout)
    localparam int B_VALID = 0;
    localparam int B_TABLE = 1;
    localparam int B_USER  = 2;
    localparam int B_SUPV  = 3;
    localparam int B_WRITE = 4;
    localparam int B_EXEC  = 5;
    localparam int B_ACC   = 6;
    localparam int B_DIRTY = 7;

    function automatic int geo_levels(geo_e g);
        case (g)
            GEO_L2_N4: return 2;
            GEO_L3_N8: return 3;
            GEO_L4_N8: return 4;
            default:   return 1;
        endcase
    endfunction

    function automatic int geo_idx_bits(geo_e g);
        return (g == GEO_L2_N4) ? 10 : 9;
    endfunction

    // log2 of the entry size in bytes
    function automatic int geo_ent_lg(geo_e g);
        return (g == GEO_L2_N4) ? 2 : 3;
    endfunction

endpackage

// File: rtl/ptw_canon.sv
module ptw_canon
    import ptw_pkg::*;
(
    input  logic [XLEN-1:0] vaddr,
    input  geo_e            geo,
    output logic            ok
);
    logic signed [XLEN-1:0] upper;
    int                     va_bits;

    always_comb begin
        va_bits = PG_SHIFT + geo_levels(geo) * geo_idx_bits(geo);
        upper   = $signed(vaddr) >>> (va_bits - 1);
        ok      = (geo != GEO_RSVD) && ((upper == '0) || (upper == '1));
    end
endmodule

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen
    import ptw_pkg::*;
(
    input  geo_e               geo,
    input  logic [LVL_W-1:0]   lvl,
    input  logic [XLEN-1:0]    vaddr,
    input  logic [XLEN-1:0]    base,
    output logic [SHIFT_W-1:0] shift,
    output logic [XLEN-1:0]    ent_addr
);
    logic [XLEN-1:0] idx;
    logic [XLEN-1:0] idx_mask;

    always_comb begin
        shift    = SHIFT_W'(int'(lvl) * geo_idx_bits(geo));
        idx_mask = (XLEN'(1) << geo_idx_bits(geo)) - XLEN'(1);
        idx      = (vaddr >> (PG_SHIFT + int'(shift))) & idx_mask;
        ent_addr = base + (idx << geo_ent_lg(geo));
    end
endmodule

// File: rtl/ptw_perm.sv
module ptw_perm #(
    parameter bit SUP_USER_OK = 1'b0
) (
    input  logic [5:0] ent_lo,
    input  logic       supervisor,
    input  logic       store,
    input  logic       fetch,
    output logic       grant
);
    import ptw_pkg::*;

    logic priv_ok;

    always_comb begin
        if (supervisor)
            priv_ok = ent_lo[B_SUPV] || (SUP_USER_OK && ent_lo[B_USER]);
        else
            priv_ok = ent_lo[B_USER];
        grant = ent_lo[B_VALID] && !ent_lo[B_TABLE] && priv_ok
             && (!store || ent_lo[B_WRITE])
             && (!fetch || ent_lo[B_EXEC]);
    end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
    import ptw_pkg::*;
#(
    parameter logic [63:0] MEM_BYTES   = 64'h0100_0000,
    parameter bit          SUP_USER_OK = 1'b0
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic [XLEN-1:0] req_vaddr,
    input  logic [XLEN-1:0] req_root,
    input  logic [1:0]      req_mode,
    input  logic            req_supervisor,
    input  logic            req_store,
    input  logic            req_fetch,
    output logic            mem_req_valid,
    input  logic            mem_req_ready,
    output logic            mem_req_write,
    output logic            mem_req_wide,
    output logic [XLEN-1:0] mem_req_addr,
    output logic [XLEN-1:0] mem_req_wdata,
    input  logic            mem_rsp_valid,
    input  logic [XLEN-1:0] mem_rsp_data,
    output logic            done,
    output logic            fault,
    output logic [XLEN-1:0] page_base
);
    walk_st_e           state;
    geo_e               geo_q;
    logic [XLEN-1:0]    vaddr_q, base_q, ent_q, ent_addr_q, result_q;
    logic [LVL_W-1:0]   lvl_q;
    logic               sup_q, st_q, fe_q, fault_q;

    geo_e               geo_in;
    logic               canon_ok;
    logic [SHIFT_W-1:0] shift;
    logic [XLEN-1:0]    ent_addr;
    logic [XLEN-1:0]    rd_ent;
    logic [XLEN-1:0]    ppn, vpn, low_mask, leaf_base;
    logic               grant, is_table, addr_oob;

    assign geo_in = geo_e'(req_mode);

    ptw_canon u_canon (
        .vaddr (req_vaddr),
        .geo   (geo_in),
        .ok    (canon_ok)
    );

    ptw_addr_gen u_agen (
        .geo      (geo_q),
        .lvl      (lvl_q),
        .vaddr    (vaddr_q),
        .base     (base_q),
        .shift    (shift),
        .ent_addr (ent_addr)
    );

    ptw_perm #(.SUP_USER_OK(SUP_USER_OK)) u_perm (
        .ent_lo     (rd_ent[5:0]),
        .supervisor (sup_q),
        .store      (st_q),
        .fetch      (fe_q),
        .grant      (grant)
    );

    always_comb begin
        rd_ent    = (geo_q == GEO_L2_N4) ? {32'b0, mem_rsp_data[31:0]} : mem_rsp_data;
        is_table  = rd_ent[B_VALID] && rd_ent[B_TABLE];
        ppn       = rd_ent >> PPN_SHIFT;
        vpn       = vaddr_q >> PG_SHIFT;
        low_mask  = (XLEN'(1) << shift) - XLEN'(1);
        leaf_base = (ppn | (vpn & low_mask)) << PG_SHIFT;
        addr_oob  = ent_addr >= MEM_BYTES;
    end

    assign req_ready     = (state == ST_IDLE);
    assign mem_req_valid = ((state == ST_RD_REQ) && !addr_oob) || (state == ST_WB);
    assign mem_req_write = (state == ST_WB);
    assign mem_req_wide  = (geo_q != GEO_L2_N4);
    assign mem_req_addr  = (state == ST_WB) ? ent_addr_q : ent_addr;
    assign mem_req_wdata = ent_q;
    assign done          = (state == ST_DONE);
    assign fault         = fault_q;
    assign page_base     = result_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            geo_q      <= GEO_L2_N4;
            vaddr_q    <= '0;
            base_q     <= '0;
            ent_q      <= '0;
            ent_addr_q <= '0;
            result_q   <= '0;
            lvl_q      <= '0;
            sup_q      <= 1'b0;
            st_q       <= 1'b0;
            fe_q       <= 1'b0;
            fault_q    <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: if (req_valid) begin
                    geo_q    <= geo_in;
                    vaddr_q  <= req_vaddr;
                    base_q   <= req_root;
                    sup_q    <= req_supervisor;
                    st_q     <= req_store;
                    fe_q     <= req_fetch;
                    lvl_q    <= LVL_W'(geo_levels(geo_in) - 1);
                    result_q <= '0;
                    fault_q  <= !canon_ok;
                    state    <= canon_ok ? ST_RD_REQ : ST_DONE;
                end
                ST_RD_REQ: begin
                    if (addr_oob) begin
                        fault_q <= 1'b1;
                        state   <= ST_DONE;
                    end else if (mem_req_ready) begin
                        ent_addr_q <= ent_addr;
                        state      <= ST_RD_WAIT;
                    end
                end
                ST_RD_WAIT: if (mem_rsp_valid) begin
                    if (is_table) begin
                        if (lvl_q == '0) begin
                            fault_q <= 1'b1;
                            state   <= ST_DONE;
                        end else begin
                            base_q <= ppn << PG_SHIFT;
                            lvl_q  <= lvl_q - LVL_W'(1);
                            state  <= ST_RD_REQ;
                        end
                    end else if (!grant) begin
                        fault_q <= 1'b1;
                        state   <= ST_DONE;
                    end else begin
                        ent_q    <= rd_ent | (XLEN'(1) << B_ACC)
                                  | (XLEN'(st_q) << B_DIRTY);
                        result_q <= leaf_base;
                        state    <= ST_WB;
                    end
                end
                ST_WB: if (mem_req_ready) begin
                    if (result_q >= MEM_BYTES) begin
                        fault_q  <= 1'b1;
                        result_q <= '0;
                    end
                    state <= ST_DONE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R11
    mem_hold_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid && !mem_req_ready |=> mem_req_valid
            && $stable(mem_req_addr) && $stable(mem_req_write));
    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    // R11
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_ready |=> !req_ready);
    // R11
    fault_zero_base_chk: assert property (@(posedge clk) disable iff (rst)
        done && fault |-> page_base == '0);
    // R4
    addr_in_range_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid && !mem_req_write |-> mem_req_addr < MEM_BYTES);
    // R7
    wb_accessed_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid && mem_req_write |-> mem_req_wdata[B_ACC]);
    // R7
    wb_dirty_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid && mem_req_write && st_q |-> mem_req_wdata[B_DIRTY]);
endmodule

// File: tb/ptw_walker_tb.sv
`timescale 1ns/1ps
module ptw_walker_tb;
    localparam logic [63:0] MEMSZ = 64'h0100_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [63:0] req_vaddr = '0, req_root = '0;
    logic [1:0]  req_mode = '0;
    logic        req_supervisor = 1'b0, req_store = 1'b0, req_fetch = 1'b0;
    logic        mem_req_valid, mem_req_write, mem_req_wide;
    logic        mem_req_ready = 1'b1;
    logic [63:0] mem_req_addr, mem_req_wdata;
    logic        mem_rsp_valid = 1'b0;
    logic [63:0] mem_rsp_data = '0;
    logic        done, fault;
    logic [63:0] page_base;

    int n_checks = 0, n_errors = 0;

    always #10 clk = ~clk;

    ptw_walker #(.MEM_BYTES(MEMSZ)) u_dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_vaddr(req_vaddr), .req_root(req_root), .req_mode(req_mode),
        .req_supervisor(req_supervisor), .req_store(req_store), .req_fetch(req_fetch),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_write(mem_req_write), .mem_req_wide(mem_req_wide),
        .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .done(done), .fault(fault), .page_base(page_base)
    );

    // memory model
    logic [7:0]  mem [longint unsigned];
    logic        slow = 1'b0;
    logic        pend = 1'b0;
    logic [63:0] pend_data = '0;
    int          n_rd = 0, n_wr = 0;
    logic [63:0] first_rd = '0, wr_addr = '0, wr_data = '0;
    logic        wr_wide = 1'b0;

    function automatic logic [7:0] rd_byte(longint unsigned a);
        return mem.exists(a) ? mem[a] : 8'h00;
    endfunction

    task automatic put(input longint unsigned a, input logic [63:0] v, input bit wide);
        for (int i = 0; i < (wide ? 8 : 4); i++) mem[a + i] = v[i*8 +: 8];
    endtask

    always @(negedge clk) begin
        logic rdy;
        logic [63:0] d;
        mem_rsp_valid <= 1'b0;
        if (pend) begin
            mem_rsp_valid <= 1'b1;
            mem_rsp_data  <= pend_data;
            pend          <= 1'b0;
        end
        rdy = slow ? ~mem_req_ready : 1'b1;
        mem_req_ready <= rdy;
        if (mem_req_valid && rdy && !rst) begin
            if (mem_req_write) begin
                put(mem_req_addr, mem_req_wdata, mem_req_wide);
                n_wr    <= n_wr + 1;
                wr_addr <= mem_req_addr;
                wr_data <= mem_req_wdata;
                wr_wide <= mem_req_wide;
            end else begin
                for (int i = 0; i < 8; i++) d[i*8 +: 8] = rd_byte(mem_req_addr + i);
                if (!mem_req_wide) d[63:32] = 32'hDEAD_BEEF;
                pend      <= 1'b1;
                pend_data <= d;
                if (n_rd == 0) first_rd <= mem_req_addr;
                n_rd <= n_rd + 1;
            end
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    logic        got_fault, busy_ready;
    logic [63:0] got_base;

    task automatic walk(input logic [1:0] m, input logic [63:0] va, input logic [63:0] root,
                        input bit sup, input bit st, input bit fe);
        int t;
        @(negedge clk);
        n_rd = 0; n_wr = 0; first_rd = '0; wr_addr = '0; wr_data = '0;
        req_valid = 1'b1; req_mode = m; req_vaddr = va; req_root = root;
        req_supervisor = sup; req_store = st; req_fetch = fe;
        @(negedge clk);
        req_valid = 1'b0;
        busy_ready = req_ready;
        t = 0;
        while (!done && t < 2000) begin
            @(negedge clk);
            t++;
        end
        if (t >= 2000) begin
            n_checks++; n_errors++;
            $display("FAIL R11: walk timeout actual busy expected done");
        end
        got_fault = fault;
        got_base  = page_base;
        @(negedge clk);
        chk("R11 done one cycle", {63'b0, done}, 64'd0);
    endtask

    task automatic t_reset();
        chk("R11 reset ready", {63'b0, req_ready}, 64'd1);
        chk("R11 reset done", {63'b0, done}, 64'd0);
        chk("R11 reset mem valid", {63'b0, mem_req_valid}, 64'd0);
    endtask

    task automatic t_mode0_page();
        put(64'h1004, 64'h803, 0);
        put(64'h200C, 64'h15409, 0);
        walk(2'd0, 64'h0040_3123, 64'h1000, 1, 0, 0);
        chk("R1 mode0 reads", n_rd, 2);
        chk("R3 first entry addr", first_rd, 64'h1004);
        chk("R12 R5 base", got_base, 64'h55000);
        chk("R12 fault", {63'b0, got_fault}, 0);
        chk("R7 wb addr", wr_addr, 64'h200C);
        chk("R7 wb data", wr_data, 64'h15449);
        chk("R7 wb narrow", {63'b0, wr_wide}, 0);
        chk("R11 busy not ready", {63'b0, busy_ready}, 0);
    endtask

    task automatic t_mode1_super();
        put(64'h3000, 64'h1003, 1);
        put(64'h4010, 64'h80019, 1);
        walk(2'd1, 64'h0045_4321, 64'h3000, 1, 1, 0);
        chk("R1 mode1 reads", n_rd, 2);
        chk("R8 superpage base", got_base, 64'h254000);
        chk("R8 fault", {63'b0, got_fault}, 0);
        chk("R7 dirty wb data", wr_data, 64'h800D9);
        chk("R7 wb wide", {63'b0, wr_wide}, 1);
    endtask

    task automatic t_mode2_stall();
        put(64'h5000, 64'h1803, 1);
        put(64'h6000, 64'h1C03, 1);
        put(64'h7000, 64'h2003, 1);
        put(64'h8038, 64'h48C25, 1);
        slow = 1'b1;
        walk(2'd2, 64'h7000, 64'h5000, 0, 0, 1);
        slow = 1'b0;
        chk("R1 mode2 reads", n_rd, 4);
        chk("R3 mode2 base", got_base, 64'h123000);
        chk("R7 mode2 wb addr", wr_addr, 64'h8038);
        chk("R7 mode2 wb data", wr_data, 64'h48C65);
    endtask

    task automatic t_noncanon();
        walk(2'd1, 64'h0000_0040_0000_0000, 64'h3000, 1, 0, 0);
        chk("R2 fault", {63'b0, got_fault}, 1);
        chk("R2 no reads", n_rd, 0);
        chk("R11 base zero", got_base, 0);
    endtask

    task automatic t_perm();
        walk(2'd0, 64'h0040_3000, 64'h1000, 0, 0, 0);
        chk("R6 user on supv page", {63'b0, got_fault}, 1);
        chk("R6 no write", n_wr, 0);
        walk(2'd0, 64'h0040_3000, 64'h1000, 1, 1, 0);
        chk("R6 store not writable", {63'b0, got_fault}, 1);
        chk("R6 store no write", n_wr, 0);
    endtask

    task automatic t_oob_entry();
        walk(2'd0, 64'h0040_0000, MEMSZ - 64'd4, 1, 0, 0);
        chk("R4 fault", {63'b0, got_fault}, 1);
        chk("R4 no reads", n_rd, 0);
    endtask

    task automatic t_table_at_leaf();
        put(64'h2010, 64'h803, 0);
        walk(2'd0, 64'h0040_4000, 64'h1000, 1, 0, 0);
        chk("R10 fault", {63'b0, got_fault}, 1);
        chk("R10 reads", n_rd, 2);
        chk("R10 no write", n_wr, 0);
    endtask

    task automatic t_result_oob();
        put(64'h2014, 64'h800009, 0);
        walk(2'd0, 64'h0040_5000, 64'h1000, 1, 0, 0);
        chk("R9 fault", {63'b0, got_fault}, 1);
        chk("R9 write still done", n_wr, 1);
        chk("R9 wb data", wr_data, 64'h800049);
        chk("R9 base zero", got_base, 0);
    endtask

    task automatic t_reserved();
        walk(2'd3, 64'h1000, 64'h1000, 1, 0, 0);
        chk("R1 reserved fault", {63'b0, got_fault}, 1);
        chk("R1 reserved no reads", n_rd, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_mode0_page();
        t_mode1_super();
        t_mode2_stall();
        t_noncanon();
        t_perm();
        t_oob_entry();
        t_table_at_leaf();
        t_result_oob();
        t_reserved();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        #2000000;
        n_checks++; n_errors++;
        $display("FAIL watchdog: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule